// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an already unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a class code, a sign, an unbiased signed exponent and a mantissa whose top bit is the explicit leading one, followed by separate guard, round and sticky bits. The conversion always truncates toward zero. It sets an inexact flag when fraction bits are discarded and an invalid flag when the value cannot be represented.

A caller pulses `start_i` for one cycle with the operand on the inputs. One cycle later `done_o` pulses, and the result and both flags are valid. They stay unchanged until the next start. Out-of-range values saturate asymmetrically: positive values go to 0x7FFFFFFF and negative values go to 0x80000000. Infinities and NaNs take the same saturating path.

Top module: `f2i_conv`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `start_i` high and low otherwise. `result_o`, `inexact_o` and `invalid_o` change only in the cycle after a start and are held until the next start.
- R2: After reset, and until the first start, `done_o`, `result_o`, `inexact_o` and `invalid_o` are all zero.
- R3: Class code 0 (zero) gives result 0 with both flags clear, whatever the sign, exponent, mantissa and guard/round/sticky inputs are.
- R4: For class code 1 (number) with exponent e in 0..31, the magnitude is floor(mant * 2^(e-(MANT_W-1))), where mant bit MANT_W-1 has weight 2^e. This is truncation toward zero.
- R5: A non-overflowing result with the sign set is the two's-complement negation of the truncated magnitude.
- R6: For a non-overflowing number, inexact is set exactly when a discarded mantissa bit or any of guard, round and sticky is nonzero.
- R7: A number with a negative exponent gives result 0 with invalid clear. Inexact is set exactly when any mantissa, guard, round or sticky bit is nonzero.
- R8: A number with exponent 32 or larger overflows.
- R9: A number whose truncated magnitude is at least 2^31 + sign overflows, so -2^31 converts exactly and +2^31 does not.
- R10: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5..7 all overflow.
- R11: On overflow, invalid is 1 and inexact is 0. The result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Convert the operand presented this cycle |
| cls_i | input | 3 | Operand class: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Unbiased exponent, two's complement |
| mant_i | input | MANT_W | Mantissa, leading one at the top bit |
| grd_i | input | 1 | Guard bit below the mantissa |
| rnd_i | input | 1 | Round bit below the guard bit |
| stk_i | input | 1 | Sticky bit, OR of all lower bits |
| done_o | output | 1 | Result valid pulse, one cycle after start |
| result_o | output | INT_W | Signed integer result |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Operand not representable; result saturated |

## Verification
The checker watches the handshake and holding behaviour on every cycle, and the mutual exclusion of the two flags. It also checks the saturation values whenever invalid is set. Alongside these, it checks the class-driven outcomes that depend only on the operand's class or exponent range: zero, non-number, exponent of 32 or more, and negative exponent. The exact truncated value, the inexact decision for in-range numbers and the boundary at 2^31 + sign are visible only in the bench's scenarios. These scenarios compare each output against a separately computed expectation.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } f2i_cls_e;
endpackage

// File: rtl/f2i_front.sv
// Classify operand and derive the alignment shift.
module f2i_front import f2i_pkg::*; #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 64,
  parameter int INT_W  = 32,
  localparam int SH_W  = $clog2(MANT_W)
) (
  input  logic [2:0]             cls_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic                   is_zero_o,
  output logic                   is_num_o,
  output logic                   exp_big_o,
  output logic                   exp_neg_o,
  output logic [SH_W-1:0]        sh_o
);
  always_comb begin
    is_zero_o = (cls_i == CLS_ZERO);
    is_num_o  = (cls_i == CLS_NUM);
    exp_neg_o = exp_i < 0;
    exp_big_o = int'(exp_i) >= INT_W;
    if (!exp_neg_o && !exp_big_o) sh_o = SH_W'(MANT_W - 1 - int'(exp_i));
    else                          sh_o = '0;
  end
endmodule

// File: rtl/f2i_align.sv
// Logarithmic right shifter collecting shifted-out bits.
module f2i_align #(
  parameter int MANT_W = 64,
  localparam int SH_W  = $clog2(MANT_W)
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [MANT_W-1:0] val_o,
  output logic              lost_o
);
  logic [MANT_W-1:0] stg [SH_W+1];
  logic              stk [SH_W+1];

  assign stg[0] = mant_i;
  assign stk[0] = 1'b0;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int SHF = 2 ** k;
    localparam logic [MANT_W-1:0] MSK = {MANT_W{1'b1}} >> (MANT_W - SHF);
    assign stg[k+1] = sh_i[k] ? (stg[k] >> SHF) : stg[k];
    assign stk[k+1] = stk[k] | (sh_i[k] & (|(stg[k] & MSK)));
  end

  assign val_o  = stg[SH_W];
  assign lost_o = stk[SH_W];
endmodule

// File: rtl/f2i_pack.sv
// Range check, sign application and flag selection.
module f2i_pack #(
  parameter int MANT_W = 64,
  parameter int INT_W  = 32
) (
  input  logic              is_zero_i,
  input  logic              is_num_i,
  input  logic              exp_big_i,
  input  logic              exp_neg_i,
  input  logic              sign_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [MANT_W-1:0] val_i,
  input  logic              lost_i,
  input  logic              grs_i,
  output logic [INT_W-1:0]  res_o,
  output logic              nx_o,
  output logic              nv_o
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0]   LIM0    = {2'b01, {(INT_W-1){1'b0}}};

  logic [INT_W-1:0] mag;
  logic             hi_bits;
  logic             lost;
  logic             too_big;
  logic             ovf;

  always_comb begin
    mag     = exp_neg_i ? '0 : val_i[INT_W-1:0];
    hi_bits = exp_neg_i ? 1'b0 : |val_i[MANT_W-1:INT_W];
    lost    = (exp_neg_i ? |mant_i : lost_i) | grs_i;
    too_big = hi_bits | ({1'b0, mag} >= (LIM0 + (INT_W+1)'(sign_i)));
    ovf     = !is_num_i | exp_big_i | too_big;
    if (is_zero_i) begin
      res_o = '0;
      nx_o  = 1'b0;
      nv_o  = 1'b0;
    end else if (ovf) begin
      res_o = sign_i ? NEG_SAT : POS_SAT;
      nx_o  = 1'b0;
      nv_o  = 1'b1;
    end else begin
      res_o = sign_i ? (~mag + 1'b1) : mag;
      nx_o  = lost;
      nv_o  = 1'b0;
    end
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 64,
  parameter int INT_W  = 32,
  localparam int SH_W  = $clog2(MANT_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [2:0]             cls_i,
  input  logic                   sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]      mant_i,
  input  logic                   grd_i,
  input  logic                   rnd_i,
  input  logic                   stk_i,
  output logic                   done_o,
  output logic [INT_W-1:0]       result_o,
  output logic                   inexact_o,
  output logic                   invalid_o
);
  logic              is_zero, is_num, exp_big, exp_neg, lost;
  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] val;
  logic [INT_W-1:0]  res_d;
  logic              nx_d, nv_d;

  f2i_front #(.EXP_W(EXP_W), .MANT_W(MANT_W), .INT_W(INT_W)) u_front (
    .cls_i     (cls_i),
    .exp_i     (exp_i),
    .is_zero_o (is_zero),
    .is_num_o  (is_num),
    .exp_big_o (exp_big),
    .exp_neg_o (exp_neg),
    .sh_o      (sh)
  );

  f2i_align #(.MANT_W(MANT_W)) u_align (
    .mant_i (mant_i),
    .sh_i   (sh),
    .val_o  (val),
    .lost_o (lost)
  );

  f2i_pack #(.MANT_W(MANT_W), .INT_W(INT_W)) u_pack (
    .is_zero_i (is_zero),
    .is_num_i  (is_num),
    .exp_big_i (exp_big),
    .exp_neg_i (exp_neg),
    .sign_i    (sign_i),
    .mant_i    (mant_i),
    .val_i     (val),
    .lost_i    (lost),
    .grs_i     (grd_i | rnd_i | stk_i),
    .res_o     (res_d),
    .nx_o      (nx_d),
    .nv_o      (nv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o  <= res_d;
        inexact_o <= nx_d;
        invalid_o <= nv_d;
      end
    end
  end
endmodule

// File: rtl/f2i_chk.sv
module f2i_chk #(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 64,
  parameter int INT_W  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [2:0]              cls_i,
  input logic                    sign_i,
  input logic signed [EXP_W-1:0] exp_i,
  input logic [MANT_W-1:0]       mant_i,
  input logic                    grd_i,
  input logic                    rnd_i,
  input logic                    stk_i,
  input logic                    done_o,
  input logic [INT_W-1:0]        result_o,
  input logic                    inexact_o,
  input logic                    invalid_o
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R1
  AST_NO_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(inexact_o) && $stable(invalid_o))); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inexact_o && invalid_o)); // R11
  AST_SAT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o == POS_SAT || result_o == NEG_SAT)); // R11
  AST_ZERO_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == 3'd0) |=> (result_o == '0 && !inexact_o && !invalid_o)); // R3
  AST_NON_NUMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i > 3'd1) |=> (invalid_o && result_o == ($past(sign_i) ? NEG_SAT : POS_SAT))); // R10
  AST_EXP_BIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == 3'd1 && int'(exp_i) >= INT_W) |=> invalid_o); // R8
  AST_EXP_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == 3'd1 && exp_i < 0) |=>
      (result_o == '0 && !invalid_o &&
       inexact_o == $past((|mant_i) | grd_i | rnd_i | stk_i))); // R7
endmodule

bind f2i_conv f2i_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W), .INT_W(INT_W)) u_chk (.*);

// File: tb/sim_f2i_conv.sv
`timescale 1ns/1ps
module sim_f2i_conv;
  localparam int EXP_W  = 16;
  localparam int MANT_W = 64;
  localparam int INT_W  = 32;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    start_i = 1'b0;
  logic [2:0]              cls_i = '0;
  logic                    sign_i = 1'b0;
  logic signed [EXP_W-1:0] exp_i = '0;
  logic [MANT_W-1:0]       mant_i = '0;
  logic                    grd_i = 1'b0, rnd_i = 1'b0, stk_i = 1'b0;
  logic                    done_o;
  logic [INT_W-1:0]        result_o;
  logic                    inexact_o, invalid_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  f2i_conv #(.EXP_W(EXP_W), .MANT_W(MANT_W), .INT_W(INT_W)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic model(input logic [2:0] c, input logic s, input int e, input logic [63:0] m,
                       input logic grs, output logic [31:0] res, output logic nx, output logic nv);
    logic [63:0] mag;
    logic ov, lost;
    ov = 0; lost = 0; mag = '0;
    if (c == 3'd0) begin res = '0; nx = 0; nv = 0; return; end
    if (c != 3'd1) ov = 1;
    else if (e >= 32) ov = 1;
    else if (e < 0) lost = (m != 0) | grs;
    else begin
      mag  = m >> (63 - e);
      lost = ((m << (e + 1)) != 0) | grs;
      if (mag >= 64'h8000_0000 + 64'(s)) ov = 1;
    end
    if (ov) begin res = s ? 32'h8000_0000 : 32'h7fff_ffff; nx = 0; nv = 1; end
    else begin res = s ? -mag[31:0] : mag[31:0]; nx = lost; nv = 0; end
  endtask

  task automatic conv(input string tag, input logic [2:0] c, input logic s, input int e,
                      input logic [63:0] m, input logic g, input logic r, input logic st);
    logic [31:0] er;
    logic enx, env;
    model(c, s, e, m, g | r | st, er, enx, env);
    @(negedge clk_i);
    cls_i = c; sign_i = s; exp_i = EXP_W'(e); mant_i = m;
    grd_i = g; rnd_i = r; stk_i = st; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk({tag, " done"}, 32'(done_o), 32'd1);
    chk({tag, " result"}, result_o, er);
    chk({tag, " inexact"}, 32'(inexact_o), 32'(enx));
    chk({tag, " invalid"}, 32'(invalid_o), 32'(env));
  endtask

  task automatic t_reset;
    chk("R2 done", 32'(done_o), 0);
    chk("R2 result", result_o, 0);
    chk("R2 flags", {30'd0, inexact_o, invalid_o}, 0);
  endtask

  task automatic t_zero;
    conv("R3 zero class", 3'd0, 1'b1, 40, 64'hdead_beef_0000_0001, 1, 1, 1);
  endtask

  task automatic t_trunc;
    conv("R4 5.75", 3'd1, 1'b0, 2, 64'hB800_0000_0000_0000, 0, 0, 0);
    conv("R4 exact 1024", 3'd1, 1'b0, 10, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R4 max pos", 3'd1, 1'b0, 30, 64'hFFFF_FFFE_0000_0000, 0, 0, 0);
    conv("R5 -5.75", 3'd1, 1'b1, 2, 64'hB800_0000_0000_0000, 0, 0, 0);
    conv("R5 -12345", 3'd1, 1'b1, 13, 64'hC0E4_0000_0000_0000, 0, 0, 0);
  endtask

  task automatic t_inexact;
    conv("R6 sticky only", 3'd1, 1'b0, 0, 64'h8000_0000_0000_0000, 0, 0, 1);
    conv("R6 guard only", 3'd1, 1'b1, 63 - 40, 64'h8000_0000_0000_0000, 1, 0, 0);
    conv("R6 low mant bit", 3'd1, 1'b0, 31, 64'h4000_0000_0000_0001, 0, 0, 0);
  endtask

  task automatic t_negexp;
    conv("R7 half", 3'd1, 1'b1, -1, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R7 all clear", 3'd1, 1'b0, -5, 64'h0, 0, 0, 0);
    conv("R7 round only", 3'd1, 1'b0, -300, 64'h0, 0, 1, 0);
  endtask

  task automatic t_bigexp;
    conv("R8 exp 32", 3'd1, 1'b0, 32, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R8 exp 200 neg", 3'd1, 1'b1, 200, 64'hC000_0000_0000_0000, 1, 0, 0);
  endtask

  task automatic t_boundary;
    conv("R9 -2^31 exact", 3'd1, 1'b1, 31, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R9 +2^31 ovf", 3'd1, 1'b0, 31, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R9 -2^31-1 ovf", 3'd1, 1'b1, 31, 64'h8000_0001_0000_0000, 0, 0, 0);
    conv("R9 -2^31 inexact", 3'd1, 1'b1, 31, 64'h8000_0000_8000_0000, 0, 0, 0);
  endtask

  task automatic t_nonnum;
    conv("R10 +inf", 3'd2, 1'b0, 0, 64'h8000_0000_0000_0000, 0, 0, 0);
    conv("R10 -qnan", 3'd3, 1'b1, 5, 64'hC000_0000_0000_0000, 0, 0, 0);
    conv("R10 snan", 3'd4, 1'b0, 0, 64'hA000_0000_0000_0000, 0, 0, 0);
    conv("R10 code 7", 3'd7, 1'b1, 0, 64'h0, 0, 0, 0);
  endtask

  task automatic t_ovf_flags;
    conv("R11 inexact dropped", 3'd1, 1'b0, 31, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1);
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic nx0, nv0;
    conv("R1 setup", 3'd1, 1'b1, 4, 64'hF000_0000_0000_0000, 0, 1, 0);
    r0 = result_o; nx0 = inexact_o; nv0 = invalid_o;
    cls_i = 3'd2; sign_i = 1'b0; exp_i = 16'sd3; mant_i = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R1 done low", 32'(done_o), 0);
      chk("R1 result held", result_o, r0);
      chk("R1 flags held", {30'd0, inexact_o, invalid_o}, {30'd0, nx0, nv0});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_zero;
    t_trunc;
    t_inexact;
    t_negexp;
    t_bigexp;
    t_boundary;
    t_nonnum;
    t_ovf_flags;
    t_hold;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule